// File: doc/BRIEF.md
# Graphics Command Packet Router

The router sits between a command FIFO and the engines of a graphics unit. It takes one 32-bit word per valid/ready handshake and reads the opcode from the top byte of the first word of each packet. A length rule keyed on that opcode says how many parameter words follow. The router keeps the words of a packet until all of them have arrived. It then sends the finished packet to one of four places: the start port of a rectangle transfer between the host and video memory, the start port of a copy inside video memory, one of eight attribute registers, or a generic primitive output that drains the buffered words under backpressure.

After a host-to-memory rectangle write starts, the router counts the 16-bit pixels of the rectangle. It then passes that many packed words, two pixels per word, straight to a pixel output and does not decode them as commands. When the pixel words are done, command decoding starts again. Two fields of the attribute registers are copied into a 13-bit status word that neighbouring logic reads.

Top module: `gpu_cmd_router`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. The packet holds 1+N words, where N is:
  - 2 for opcode 0x02, and 0 for the rest of 0x00–0x1F.
  - For 0x20–0x3F, V*(1+b2)+(b4 ? V-1 : 0), with V = 4 if b3 is set and 3 otherwise.
  - For 0x40–0x5F, (b4 ? 3 : 2)+b3.
  - For 0x60–0x7F, 1+b2+(b4:b3==0 ? 1 : 0).
  - 3 for 0x80–0x9F, 2 for 0xA0–0xDF, and 0 for 0xE0–0xFF.
  - Here bK means bit K of the opcode.
- R2: Opcodes 0xA0–0xBF (write) and 0xC0–0xDF (read) raise `xferStart` for one cycle. This happens in the cycle after the third word is accepted. `xferIsRead` is 0 for a write and 1 for a read, `xferPos` is word 1 and `xferSize` is word 2. A read never enters the pixel phase.
- R3: Opcodes 0x80–0x9F raise `copyStart` for one cycle, in the cycle after the fourth word is accepted. `copySrc`, `copyDst` and `copySize` are words 1, 2 and 3.
- R4: Opcodes 0xE0–0xE7 store the whole command word into attribute register (opcode & 7). The new value shows on `attrFlat[32*k +: 32]` from the clock edge that accepts the word.
- R5: `statusWord[10:0]` equals attribute register 1 bits 10:0 and `statusWord[12:11]` equals attribute register 6 bits 1:0. Both change at the same edge as the register write.
- R6: A packet whose words have not all arrived produces no start strobe, no primitive output and no register write. The router keeps waiting for the missing words.
- R7: After a write start, the next ceil(W*H/2) accepted words appear on `pixData` with `pixValid` and are not decoded. W = ((size[9:0]-1) mod 1024)+1 and H = ((size[24:16]-1) mod 512)+1. Decoding resumes on the word after the last pixel word.
- R8: Every packet that is not a transfer, copy or attribute-register write is sent on the primitive port. Its words come out in order, one per `primValid`&&`primReady` handshake. `primSop` is set on the first word and `primCount` = 1+N. `inReady` stays low during the emission. While `primReady` is low, the outputs hold their values.
- R9: After reset, each attribute register k holds (0xE0+k)<<24, `statusWord` is 0, no strobe or valid is active, and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Command FIFO word valid |
| inData | input | 32 | Command FIFO word |
| inReady | output | 1 | Router accepts the word this cycle |
| pixValid | output | 1 | Pixel word valid during a rectangle write |
| pixData | output | 32 | Packed pixel word |
| pixReady | input | 1 | Transfer unit takes the pixel word |
| xferStart | output | 1 | One-cycle rectangle transfer start |
| xferIsRead | output | 1 | 1 = memory-to-host, 0 = host-to-memory |
| xferPos | output | 32 | Rectangle position word |
| xferSize | output | 32 | Rectangle size word |
| copyStart | output | 1 | One-cycle memory copy start |
| copySrc | output | 32 | Copy source word |
| copyDst | output | 32 | Copy destination word |
| copySize | output | 32 | Copy size word |
| primValid | output | 1 | Primitive word valid |
| primSop | output | 1 | First word of a primitive packet |
| primCount | output | 4 | Words in the current primitive packet |
| primData | output | 32 | Primitive word |
| primReady | input | 1 | Downstream takes the primitive word |
| attrFlat | output | 256 | Eight attribute registers, register k at bits 32k+31:32k |
| statusWord | output | 13 | Status fields copied from attribute registers |

## Verification
The assertions check the following on every cycle:
- At most one route strobe is active at a time.
- `inReady` stays low during a primitive emission, and the primitive outputs hold while stalled.
- Nothing is routed while a packet is still incomplete.
- No decode happens during the pixel phase, and a read start has no pixel phase.
- A register write lands in the register and in the status bits.

Only the bench scenarios show the values themselves:
- the per-opcode word counts,
- the order and contents of emitted words,
- the exact number of pixel words taken for a given rectangle size,
- the return to decoding after a write.

// File: rtl/gpu_cmd_pkg.sv
`timescale 1ns/1ps
package gpu_cmd_pkg;
  localparam int WORD_W  = 32;
  localparam int PKT_MAX = 12;
  localparam int IDX_W   = $clog2(PKT_MAX);
  localparam int ATTR_N  = 8;

  typedef enum logic [2:0] {RT_PRIM, RT_WRITE, RT_READ, RT_COPY, RT_ATTR} route_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             attrEn;
    logic [2:0]       attrIdx;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;

  function automatic route_t routeOf(input logic [7:0] op);
    if (op[7:5] == 3'b101)      return RT_WRITE;
    else if (op[7:5] == 3'b110) return RT_READ;
    else if (op[7:5] == 3'b100) return RT_COPY;
    else if (op[7:3] == 5'b11100) return RT_ATTR;
    else                        return RT_PRIM;
  endfunction

  function automatic logic [IDX_W-1:0] extraWords(input logic [7:0] op);
    int n;
    int v;
    v = op[3] ? 4 : 3;
    case (op[7:5])
      3'b000: n = (op == 8'h02) ? 2 : 0;
      3'b001: n = v * (1 + int'(op[2])) + (op[4] ? v - 1 : 0);
      3'b010: n = (op[4] ? 3 : 2) + int'(op[3]);
      3'b011: n = 1 + int'(op[2]) + ((op[4:3] == 2'b00) ? 1 : 0);
      3'b100: n = 3;
      3'b101, 3'b110: n = 2;
      default: n = 0;
    endcase
    return n[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/gpu_cmd_datapath.sv
`timescale 1ns/1ps
module gpu_cmd_datapath
  import gpu_cmd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  st,
  input  logic [WORD_W-1:0]        inData,
  output logic [WORD_W-1:0]        rdWord,
  output logic [WORD_W-1:0]        parm1,
  output logic [WORD_W-1:0]        parm2,
  output logic [WORD_W-1:0]        parm3,
  output logic [ATTR_N*WORD_W-1:0] attrFlat,
  output logic [12:0]              statusWord
);
  logic [WORD_W-1:0] pktBuf [PKT_MAX];
  logic [WORD_W-1:0] attrReg [ATTR_N];

  always_ff @(posedge clk) begin
    if (st.wrEn) pktBuf[st.wrIdx] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < ATTR_N; k++) attrReg[k] <= {8'hE0 + 8'(k), 24'h0};
    end else if (st.attrEn) begin
      attrReg[st.attrIdx] <= inData;
    end
  end

  assign rdWord     = pktBuf[st.rdIdx];
  assign parm1      = pktBuf[1];
  assign parm2      = pktBuf[2];
  assign parm3      = pktBuf[3];
  assign statusWord = {attrReg[6][1:0], attrReg[1][10:0]};

  for (genvar g = 0; g < ATTR_N; g++) begin : g_flat
    assign attrFlat[g*WORD_W +: WORD_W] = attrReg[g];
  end

  // R4: a register write lands with the whole word
  p_attr_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.attrEn |=> attrFlat[$past(st.attrIdx)*WORD_W +: WORD_W] == $past(inData));
  // R5: a write to register 1 shows in the low status bits at once
  p_status_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.attrEn && st.attrIdx == 3'd1) |=> statusWord[10:0] == $past(inData[10:0]));
  // R5: a write to register 6 shows in status bits 12:11
  p_status_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.attrEn && st.attrIdx == 3'd6) |=> statusWord[12:11] == $past(inData[1:0]));
endmodule

// File: rtl/gpu_cmd_ctrl.sv
`timescale 1ns/1ps
module gpu_cmd_ctrl
  import gpu_cmd_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  output logic              pixValid,
  input  logic              pixReady,
  output logic              xferStart,
  output logic              xferIsRead,
  output logic              copyStart,
  output logic              primValid,
  output logic              primSop,
  output logic [IDX_W-1:0]  primCount,
  input  logic              primReady,
  output strobe_t           st
);
  localparam int PIXW = XW + YW + 2;

  typedef enum logic [1:0] {S_COLLECT, S_EMIT, S_PIXEL} state_t;

  state_t           state;
  logic [IDX_W-1:0] wordCnt, needCnt, emitIdx, emitLast;
  logic [7:0]       opcReg;
  logic [PIXW-1:0]  pixLeft;
  logic             xferStartQ, xferReadQ, copyStartQ;

  logic             fire, firstWord, collectFire, pktDone;
  logic [7:0]       curOp;
  logic [IDX_W-1:0] curNeed;
  route_t           curRoute;

  logic [XW-1:0]   wM1;
  logic [YW-1:0]   hM1;
  logic [XW:0]     wFull;
  logic [YW:0]     hFull;
  logic [PIXW-1:0] pixProd, pixInit;

  always_comb begin
    wM1     = inData[XW-1:0] - 1'b1;
    hM1     = inData[16 +: YW] - 1'b1;
    wFull   = {1'b0, wM1} + 1'b1;
    hFull   = {1'b0, hM1} + 1'b1;
    pixProd = PIXW'(wFull) * PIXW'(hFull);
    pixInit = ((pixProd + PIXW'(1)) >> 1) - PIXW'(1);
  end

  always_comb begin
    inReady     = (state == S_COLLECT) || (state == S_PIXEL && pixReady);
    fire        = inValid && inReady;
    firstWord   = (wordCnt == '0);
    curOp       = firstWord ? inData[31:24] : opcReg;
    curNeed     = firstWord ? extraWords(inData[31:24]) : needCnt;
    curRoute    = routeOf(curOp);
    collectFire = (state == S_COLLECT) && fire;
    pktDone     = collectFire && (wordCnt == curNeed);

    pixValid   = (state == S_PIXEL) && inValid;
    primValid  = (state == S_EMIT);
    primSop    = primValid && (emitIdx == '0);
    primCount  = emitLast + 1'b1;
    xferStart  = xferStartQ;
    xferIsRead = xferReadQ;
    copyStart  = copyStartQ;

    st.wrEn    = collectFire;
    st.wrIdx   = wordCnt;
    st.attrEn  = pktDone && (curRoute == RT_ATTR);
    st.attrIdx = curOp[2:0];
    st.rdIdx   = emitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_COLLECT;
      wordCnt    <= '0;
      needCnt    <= '0;
      opcReg     <= '0;
      emitIdx    <= '0;
      emitLast   <= '0;
      pixLeft    <= '0;
      xferStartQ <= 1'b0;
      xferReadQ  <= 1'b0;
      copyStartQ <= 1'b0;
    end else begin
      xferStartQ <= 1'b0;
      copyStartQ <= 1'b0;
      case (state)
        S_COLLECT: begin
          if (collectFire) begin
            if (pktDone) begin
              wordCnt <= '0;
              case (curRoute)
                RT_WRITE: begin
                  xferStartQ <= 1'b1;
                  xferReadQ  <= 1'b0;
                  pixLeft    <= pixInit;
                  state      <= S_PIXEL;
                end
                RT_READ: begin
                  xferStartQ <= 1'b1;
                  xferReadQ  <= 1'b1;
                end
                RT_COPY: copyStartQ <= 1'b1;
                RT_PRIM: begin
                  emitIdx  <= '0;
                  emitLast <= curNeed;
                  state    <= S_EMIT;
                end
                default: ;
              endcase
            end else begin
              if (firstWord) begin
                opcReg  <= inData[31:24];
                needCnt <= curNeed;
              end
              wordCnt <= wordCnt + 1'b1;
            end
          end
        end
        S_EMIT: begin
          if (primReady) begin
            if (emitIdx == emitLast) state <= S_COLLECT;
            else emitIdx <= emitIdx + 1'b1;
          end
        end
        S_PIXEL: begin
          if (fire) begin
            if (pixLeft == '0) state <= S_COLLECT;
            else pixLeft <= pixLeft - 1'b1;
          end
        end
        default: state <= S_COLLECT;
      endcase
    end
  end

  // R2/R3/R8: route strobes never overlap
  p_one_route_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xferStart, copyStart, primSop}));
  // R8: the FIFO is stalled during emission
  p_stall_fifo_r8: assert property (@(posedge clk) disable iff (!rstN)
    primValid |-> !inReady);
  // R8: a stalled primitive word holds its framing
  p_hold_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (primValid && !primReady) |=> (primValid && $stable(primSop) && $stable(primCount)));
  // R6: an incomplete packet routes nothing
  p_wait_more_r6: assert property (@(posedge clk) disable iff (!rstN)
    (collectFire && !pktDone) |=> (!xferStart && !copyStart && !primValid));
  // R7: pixel words are never decoded or buffered
  p_no_decode_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (!st.attrEn && !st.wrEn));
  // R2: a read start is not followed by a pixel phase
  p_read_nopix_r2: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && xferIsRead) |-> !pixValid);
endmodule

// File: rtl/gpu_cmd_router.sv
`timescale 1ns/1ps
module gpu_cmd_router
  import gpu_cmd_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [WORD_W-1:0]        inData,
  output logic                     inReady,
  output logic                     pixValid,
  output logic [WORD_W-1:0]        pixData,
  input  logic                     pixReady,
  output logic                     xferStart,
  output logic                     xferIsRead,
  output logic [WORD_W-1:0]        xferPos,
  output logic [WORD_W-1:0]        xferSize,
  output logic                     copyStart,
  output logic [WORD_W-1:0]        copySrc,
  output logic [WORD_W-1:0]        copyDst,
  output logic [WORD_W-1:0]        copySize,
  output logic                     primValid,
  output logic                     primSop,
  output logic [IDX_W-1:0]         primCount,
  output logic [WORD_W-1:0]        primData,
  input  logic                     primReady,
  output logic [ATTR_N*WORD_W-1:0] attrFlat,
  output logic [12:0]              statusWord
);
  strobe_t           st;
  logic [WORD_W-1:0] rdWord, parm1, parm2, parm3;

  gpu_cmd_ctrl #(.XW(XW), .YW(YW)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .pixValid(pixValid), .pixReady(pixReady), .xferStart(xferStart),
    .xferIsRead(xferIsRead), .copyStart(copyStart), .primValid(primValid),
    .primSop(primSop), .primCount(primCount), .primReady(primReady), .st(st)
  );

  gpu_cmd_datapath u_data (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData), .rdWord(rdWord),
    .parm1(parm1), .parm2(parm2), .parm3(parm3), .attrFlat(attrFlat),
    .statusWord(statusWord)
  );

  assign pixData  = inData;
  assign xferPos  = parm1;
  assign xferSize = parm2;
  assign copySrc  = parm1;
  assign copyDst  = parm2;
  assign copySize = parm3;
  assign primData = rdWord;

  // R8: a stalled primitive word keeps its data
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (primValid && !primReady) |=> $stable(primData));
endmodule

// File: tb/sim_gpu_cmd_router.sv
`timescale 1ns/1ps
module sim_gpu_cmd_router;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic         inValid = 1'b0;
  logic [31:0]  inData = '0;
  logic         inReady, pixValid, pixReady, xferStart, xferIsRead, copyStart;
  logic [31:0]  pixData, xferPos, xferSize, copySrc, copyDst, copySize, primData;
  logic         primValid, primSop, primReady;
  logic [3:0]   primCount;
  logic [255:0] attrFlat;
  logic [12:0]  statusWord;

  gpu_cmd_router u0 (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  int tick = 0;
  bit stallMode = 0;

  // captures
  logic [31:0] capWord [16];
  logic        capSop [16];
  logic [3:0]  capCnt;
  int capN = 0, xferN = 0, copyN = 0, pixN = 0, stallViol = 0;
  logic        lastRead;
  logic [31:0] lastPos, lastSize, lastSrc, lastDst, lastCsz, lastPix;

  // {opcode, extra words, route: 0 prim, 2 read, 3 copy, 4 attr}
  localparam logic [14:0] VEC [16] = '{
    {8'h20, 4'd3, 3'd0}, {8'h24, 4'd6, 3'd0}, {8'h2C, 4'd8, 3'd0}, {8'h3C, 4'd11, 3'd0},
    {8'h30, 4'd5, 3'd0}, {8'h40, 4'd2, 3'd0}, {8'h58, 4'd4, 3'd0}, {8'h60, 4'd2, 3'd0},
    {8'h68, 4'd1, 3'd0}, {8'h74, 4'd2, 3'd0}, {8'h02, 4'd2, 3'd0}, {8'h00, 4'd0, 3'd0},
    {8'hE8, 4'd0, 3'd0}, {8'h88, 4'd3, 3'd3}, {8'hC4, 4'd2, 3'd2}, {8'hE3, 4'd0, 3'd4}
  };

  always @(posedge clk) begin
    #1;
    tick++;
    primReady = stallMode ? (tick % 3 != 0) : 1'b1;
    pixReady  = (tick % 4 != 1);
  end

  always @(negedge clk) begin
    if (primValid && inReady) stallViol++;
    if (primValid && primReady) begin
      if (capN < 16) begin
        capWord[capN] = primData;
        capSop[capN]  = primSop;
      end
      capCnt = primCount;
      capN++;
    end
    if (xferStart) begin
      xferN++; lastRead = xferIsRead; lastPos = xferPos; lastSize = xferSize;
    end
    if (copyStart) begin
      copyN++; lastSrc = copySrc; lastDst = copyDst; lastCsz = copySize;
    end
    if (pixValid && pixReady) begin
      pixN++; lastPix = pixData;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    inValid = 1'b1;
    inData  = w;
    do @(negedge clk); while (!inReady);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic clearCaps();
    capN = 0; xferN = 0; copyN = 0; pixN = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w [12];
    logic [31:0] stSave;
    primReady = 1'b1;
    pixReady  = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 inReady", 32'(inReady), 32'd1);
    check("R9 primValid", 32'(primValid), 32'd0);
    check("R9 status", 32'(statusWord), 32'd0);
    for (int k = 0; k < 8; k++)
      check("R9 attr reset", attrFlat[k*32 +: 32], {8'hE0 + 8'(k), 24'h0});
    @(posedge clk); #1;

    // table walk: R1 lengths, R8 emission, R3 copy, R2 read, R4 store
    for (int i = 0; i < 16; i++) begin
      logic [7:0] op;
      logic [3:0] len;
      logic [2:0] rt;
      op = VEC[i][14:7]; len = VEC[i][6:3]; rt = VEC[i][2:0];
      stallMode = (i % 2 == 1);
      clearCaps();
      w[0] = {op, 8'(i), 16'h5A00 + 16'(i)};
      for (int k = 1; k < 12; k++) w[k] = 32'hC0DE0000 + 32'(i * 16 + k);
      stSave = 32'(statusWord);
      for (int k = 0; k <= int'(len); k++) sendWord(w[k]);
      idle(40);
      if (rt == 3'd0) begin
        check("R1 word count", 32'(capN), 32'(len) + 1);
        check("R8 count field", 32'(capCnt), 32'(len) + 1);
        check("R8 first sop", 32'(capSop[0]), 32'd1);
        for (int k = 0; k <= int'(len); k++) begin
          check("R8 word order", capWord[k], w[k]);
          if (k > 0) check("R8 later sop", 32'(capSop[k]), 32'd0);
        end
      end else if (rt == 3'd3) begin
        check("R3 copy strobes", 32'(copyN), 32'd1);
        check("R3 copy src", lastSrc, w[1]);
        check("R3 copy dst", lastDst, w[2]);
        check("R3 copy size", lastCsz, w[3]);
        check("R3 no prim", 32'(capN), 32'd0);
      end else if (rt == 3'd2) begin
        check("R2 read strobes", 32'(xferN), 32'd1);
        check("R2 read flag", 32'(lastRead), 32'd1);
        check("R2 read pos", lastPos, w[1]);
        check("R2 read size", lastSize, w[2]);
        check("R2 read no pixels", 32'(pixN), 32'd0);
      end else begin
        check("R4 attr3 stored", attrFlat[3*32 +: 32], w[0]);
        check("R4 no prim", 32'(capN), 32'd0);
        check("R5 status untouched", 32'(statusWord), stSave);
      end
    end
    stallMode = 1'b1;

    // R6: partial packet waits
    clearCaps();
    w[0] = 32'h2C000000;
    for (int k = 1; k < 9; k++) w[k] = 32'hAB000000 + 32'(k);
    for (int k = 0; k < 5; k++) sendWord(w[k]);
    idle(8);
    check("R6 no output while partial", 32'(capN), 32'd0);
    for (int k = 5; k < 9; k++) sendWord(w[k]);
    idle(30);
    check("R6 full packet after completion", 32'(capN), 32'd9);
    check("R6 last word", capWord[8], w[8]);

    // R4/R5: status mirroring
    sendWord(32'hE10007FF);
    @(negedge clk);
    check("R5 low status", 32'(statusWord[10:0]), 32'h7FF);
    check("R4 attr1 word", attrFlat[1*32 +: 32], 32'hE10007FF);
    @(posedge clk); #1;
    sendWord(32'hE6FFFFFE);
    @(negedge clk);
    check("R5 high status", 32'(statusWord[12:11]), 32'd2);
    check("R5 low kept", 32'(statusWord[10:0]), 32'h7FF);
    @(posedge clk); #1;

    // R7: 3x3 write -> 5 pixel words, command-like data not decoded
    clearCaps();
    sendWord(32'hA0000000);
    sendWord(32'h00050004);
    sendWord(32'h00030003);
    for (int k = 0; k < 5; k++) sendWord(32'hE1000000 + 32'(k));
    idle(4);
    check("R2 write strobe", 32'(xferN), 32'd1);
    check("R2 write flag", 32'(lastRead), 32'd0);
    check("R2 write size", lastSize, 32'h00030003);
    check("R7 pixel words 3x3", 32'(pixN), 32'd5);
    check("R7 last pixel data", lastPix, 32'hE1000004);
    check("R7 attr1 untouched", attrFlat[1*32 +: 32], 32'hE10007FF);
    check("R7 status untouched", 32'(statusWord[10:0]), 32'h7FF);
    sendWord(32'h00000000);
    idle(6);
    check("R7 decode resumes", 32'(capN), 32'd1);

    // R7: 1x1 write -> 1 word, 4x2 write -> 4 words
    clearCaps();
    sendWord(32'hBF000000); sendWord(32'h0); sendWord(32'h00010001);
    sendWord(32'h12345678);
    sendWord(32'hE2000001);
    idle(4);
    check("R7 pixel words 1x1", 32'(pixN), 32'd1);
    check("R4 decode after 1x1", attrFlat[2*32 +: 32], 32'hE2000001);
    clearCaps();
    sendWord(32'hA1000000); sendWord(32'h0); sendWord(32'h00020004);
    for (int k = 0; k < 4; k++) sendWord(32'h55550000 + 32'(k));
    sendWord(32'h02000000); sendWord(32'h1); sendWord(32'h2);
    idle(20);
    check("R7 pixel words 4x2", 32'(pixN), 32'd4);
    check("R1 opcode 02 after write", 32'(capN), 32'd3);

    check("R8 fifo stalled during emission", 32'(stallViol), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule